// File: doc/BRIEF.md
# Indexed-Access Watchdog Timer

This block is a watchdog timer whose configuration lives behind a two-port indirect window. Software writes a register number to an index port, then reads or writes that register through a data port. The window is closed after reset and stays closed until a key sequence opens it. While it is closed, data-port writes have no effect and data-port reads return all ones.

Once enabled, a counter moves up by one on each tick strobe. The tick comes from an external prescaler. When the counter reaches a 24-bit terminal count held in three byte registers, a sticky timeout flag sets and the counter stops. A 4-bit selector then routes the event to nothing, to a one-cycle system reset pulse, or to one line of a 14-bit one-hot interrupt bus. Software clears the event either by disabling the timer or by writing a clear bit in the status register. Both actions also return the counter to zero.

Top module: `wdt_indexed`

## Requirements
- R1: After reset the window is closed, the timer is disabled, all configuration bytes are 00h, the timeout flag is clear and `sysResetOut` and `irqOut` are low. A read of the index port returns 00h.
- R2: Two consecutive index-port writes of 87h open the window. Any other index-port write between them breaks the sequence. An index-port write of AAh closes the window.
- R3: While the window is closed, data-port writes change no register and data-port reads return FFh. The index port always accepts writes and reads back the last value written to it. A data-port read at an index that maps to no register returns 00h.
- R4: Register 37h is a plain read/write byte, and its bit 6 enables the timer. While the timer is enabled, each cycle with `tick` high advances the counter by one, starting from zero.
- R5: The terminal count is stored with its least significant byte at index 39h, its middle byte at 3Ah and its most significant byte at 3Bh. The bytes read back as written. The timeout flag sets on a tick that finds the counter at or above the terminal count. This is the (N+1)th tick after enabling for a terminal count N, so N = 0 times out on the first tick.
- R6: Bit 7 of register 3Ch reads the timeout flag and bit 6 always reads 0. After a timeout, further ticks leave the flag and the selected output set.
- R7: A write to 37h with bit 6 = 0 stops the timer and clears the counter and the flag. A write to 3Ch with bit 6 = 1 clears the counter and the flag, and the timer keeps running from zero.
- R8: Bits [5:0] of 3Ch are stored. A write to 3Ch with bit 6 = 1 leaves them unchanged, and a write with bit 6 = 0 loads them.
- R9: Bits [7:4] of register 38h select the timeout action:
  - 0: no output.
  - 1: `sysResetOut` is high for exactly the one cycle that follows the edge on which the flag sets.
  - k from 2 to 15: `irqOut[k-2]` is high while the flag is set, and every other line is low.
- R10: A change to any terminal-count byte while the timer runs applies at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Port address: 22h selects the index port, 23h selects the data port |
| busWrEn | input | 1 | Write strobe for the addressed port |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for the addressed port |
| tick | input | 1 | Count strobe from an external prescaler |
| sysResetOut | output | 1 | One-cycle reset request on timeout |
| irqOut | output | 14 | One-hot interrupt request lines |

## Verification
The hardest case to reach from the ports is a terminal count that needs a nonzero upper byte. Without one, the byte ordering of the compare value is never exercised. The bench therefore programs 0x000100 through the middle byte alone and drives 256 ticks with no timeout, then checks that the 257th tick fires. The terminal count is also lowered below the running count mid-flight, which shows that the counter stops rather than wrapping. A broken unlock sequence is tried before the valid one, to show that only back-to-back keys open the window.

// File: rtl/wdt_idx_pkg.sv
package wdt_idx_pkg;
  localparam logic [7:0] IDX_CTRL   = 8'h37;
  localparam logic [7:0] IDX_ACTION = 8'h38;
  localparam logic [7:0] IDX_CMP0   = 8'h39;
  localparam logic [7:0] IDX_STATUS = 8'h3C;
  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;

  typedef struct packed {
    logic run;       // timer enabled level
    logic clearAll;  // one-cycle clear of counter and flag
  } wdtCmd_t;
endpackage

// File: rtl/wdt_idx_ctrl.sv
module wdt_idx_ctrl
  import wdt_idx_pkg::*;
#(
  parameter int CMP_BYTES = 3,
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h23,
  localparam int CNT_W = 8 * CMP_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic             timeoutFlag,
  output wdtCmd_t          cmd,
  output logic [CNT_W-1:0] cmpValue,
  output logic [3:0]       actionSel
);
  logic [7:0] idxReg;
  logic       keySeen;
  logic       unlocked;
  logic [7:0] ctrlReg;
  logic [7:0] actReg;
  logic [5:0] statusLow;
  logic       idxWr;
  logic       dataWr;

  assign idxWr  = busWrEn && (busAddr == INDEX_PORT);
  assign dataWr = busWrEn && (busAddr == DATA_PORT) && unlocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= 8'h00;
      keySeen  <= 1'b0;
      unlocked <= 1'b0;
    end else if (idxWr) begin
      idxReg <= busWrData;
      if (busWrData == KEY_OPEN) begin
        if (keySeen) unlocked <= 1'b1;
        keySeen <= !keySeen;
      end else begin
        keySeen <= 1'b0;
        if (busWrData == KEY_CLOSE) unlocked <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= 8'h00;
      actReg    <= 8'h00;
      statusLow <= 6'h00;
    end else if (dataWr) begin
      case (idxReg)
        IDX_CTRL:   ctrlReg <= busWrData;
        IDX_ACTION: actReg  <= busWrData;
        IDX_STATUS: if (!busWrData[6]) statusLow <= busWrData[5:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CMP_BYTES; g++) begin : g_cmp
    localparam logic [7:0] MY_IDX = IDX_CMP0 + 8'(g);
    logic [7:0] cmpByte;
    always_ff @(posedge clk) begin
      if (!rstN) cmpByte <= 8'h00;
      else if (dataWr && idxReg == MY_IDX) cmpByte <= busWrData;
    end
    assign cmpValue[8*g +: 8] = cmpByte;
  end

  assign cmd.run      = ctrlReg[6];
  assign cmd.clearAll = dataWr &&
                        ((idxReg == IDX_CTRL && !busWrData[6]) ||
                         (idxReg == IDX_STATUS && busWrData[6]));
  assign actionSel    = actReg[7:4];

  always_comb begin
    busRdData = 8'h00;
    if (busAddr == INDEX_PORT) begin
      busRdData = idxReg;
    end else if (busAddr == DATA_PORT) begin
      if (!unlocked) begin
        busRdData = 8'hFF;
      end else begin
        case (idxReg)
          IDX_CTRL:   busRdData = ctrlReg;
          IDX_ACTION: busRdData = actReg;
          IDX_STATUS: busRdData = {timeoutFlag, 1'b0, statusLow};
          default:    busRdData = 8'h00;
        endcase
        for (int i = 0; i < CMP_BYTES; i++)
          if (idxReg == IDX_CMP0 + 8'(i)) busRdData = cmpValue[8*i +: 8];
      end
    end
  end

  // R3: a closed window leaves configuration untouched
  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && busWrEn && busAddr == DATA_PORT)
      |=> ($stable(ctrlReg) && $stable(actReg) && $stable(statusLow) && $stable(cmpValue)));

  // R2: the window can only open on an index-port key write
  assert_open_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(idxWr) && $past(busWrData) == KEY_OPEN));
endmodule

// File: rtl/wdt_idx_datapath.sv
module wdt_idx_datapath
  import wdt_idx_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int IRQ_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  wdtCmd_t          cmd,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic [3:0]       actionSel,
  output logic             timeoutFlag,
  output logic             resetPulse,
  output logic [IRQ_W-1:0] irqOut
);
  logic [CNT_W-1:0] count;
  logic             hitNow;

  assign hitNow = cmd.run && !cmd.clearAll && !timeoutFlag && tickIn &&
                  (count >= cmpValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      timeoutFlag <= 1'b0;
      resetPulse  <= 1'b0;
    end else begin
      resetPulse <= hitNow && (actionSel == 4'd1);
      if (!cmd.run || cmd.clearAll) begin
        count       <= '0;
        timeoutFlag <= 1'b0;
      end else if (tickIn && !timeoutFlag) begin
        if (count >= cmpValue) timeoutFlag <= 1'b1;
        else                   count <= count + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < IRQ_W; g++) begin : g_irq
    assign irqOut[g] = timeoutFlag && (actionSel == 4'(g + 2));
  end

  // R6: after timeout the counter and flag hold until cleared
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && cmd.run && !cmd.clearAll) |=> (timeoutFlag && $stable(count)));

  // R7: a clear strobe drops the flag and counter
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (!timeoutFlag && count == '0));

  // R5: timeout only arises on a tick
  assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(tickIn));

  // R9: reset request lasts one cycle, interrupt lines one-hot at most
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse);
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));
endmodule

// File: rtl/wdt_indexed.sv
module wdt_indexed
  import wdt_idx_pkg::*;
#(
  parameter int CMP_BYTES = 3,
  parameter int IRQ_W = 14,
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h23,
  localparam int CNT_W = 8 * CMP_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic [7:0]       busWrData,
  output logic [7:0]       busRdData,
  input  logic             tick,
  output logic             sysResetOut,
  output logic [IRQ_W-1:0] irqOut
);
  wdtCmd_t          cmd;
  logic [CNT_W-1:0] cmpValue;
  logic [3:0]       actionSel;
  logic             timeoutFlag;

  wdt_idx_ctrl #(
    .CMP_BYTES(CMP_BYTES), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .timeoutFlag(timeoutFlag),
    .cmd(cmd), .cmpValue(cmpValue), .actionSel(actionSel)
  );

  wdt_idx_datapath #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tick), .cmd(cmd), .cmpValue(cmpValue),
    .actionSel(actionSel), .timeoutFlag(timeoutFlag), .resetPulse(sysResetOut),
    .irqOut(irqOut)
  );
endmodule

// File: tb/tb_wdt_indexed.sv
module tb_wdt_indexed;
  localparam logic [7:0] IP = 8'h22;
  localparam logic [7:0] DP = 8'h23;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = 8'h00;
  logic [7:0]  busRdData;
  logic        tick = 1'b0;
  logic        sysResetOut;
  logic [13:0] irqOut;

  int checks = 0;
  int errors = 0;

  wdt_indexed dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick),
    .sysResetOut(sysResetOut), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] d);
    wr(IP, idx);
    wr(DP, d);
  endtask

  task automatic getReg(input logic [7:0] idx, output logic [7:0] v);
    wr(IP, idx);
    busAddr = DP;
    #1 v = busRdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic flagNow(output logic f);
    logic [7:0] v;
    getReg(8'h3C, v);
    f = v[7];
  endtask

  task automatic testReset();
    logic [7:0] v;
    busAddr = IP; #1 chk("R1 index reads 00", busRdData, 8'h00);
    busAddr = DP; #1 chk("R1 closed read", busRdData, 8'hFF);
    chk("R1 irq idle", irqOut, 14'h0);
    chk("R1 reset idle", sysResetOut, 1'b0);
    v = 8'h00;
  endtask

  task automatic testLock();
    logic [7:0] v;
    setReg(8'h37, 8'h40);
    getReg(8'h37, v);
    chk("R3 closed read FF", v, 8'hFF);
    busAddr = IP; #1 chk("R3 index readback", busRdData, 8'h37);
    wr(IP, 8'h87); wr(IP, 8'h12); wr(IP, 8'h87);
    busAddr = DP; #1 chk("R2 broken key stays closed", busRdData, 8'hFF);
    wr(IP, 8'h87);
    busAddr = DP; #1 chk("R2 open unmapped index", busRdData, 8'h00);
    getReg(8'h37, v);
    chk("R3 locked write ignored", v, 8'h00);
    wr(IP, 8'hAA);
    busAddr = DP; #1 chk("R2 close key", busRdData, 8'hFF);
    wr(IP, 8'h87); wr(IP, 8'h87);
  endtask

  task automatic testIrqTimeout();
    logic f;
    logic [7:0] v;
    setReg(8'h39, 8'h05);
    setReg(8'h38, 8'h20);
    getReg(8'h39, v); chk("R5 cmp byte readback", v, 8'h05);
    getReg(8'h38, v); chk("R9 action readback", v, 8'h20);
    setReg(8'h37, 8'h40);
    getReg(8'h37, v); chk("R4 ctrl readback", v, 8'h40);
    ticks(5);
    flagNow(f); chk("R5 no timeout after N ticks", f, 1'b0);
    chk("R9 irq low before", irqOut, 14'h0);
    ticks(1);
    flagNow(f); chk("R6 flag read after N+1", f, 1'b1);
    chk("R9 irq line 0", irqOut, 14'h0001);
    getReg(8'h3C, v); chk("R6 bit6 reads 0", v[6], 1'b0);
    ticks(4);
    chk("R6 irq held", irqOut, 14'h0001);
  endtask

  task automatic testClearStatus();
    logic f;
    logic [7:0] v;
    setReg(8'h3C, 8'h40);
    flagNow(f); chk("R7 status clear drops flag", f, 1'b0);
    chk("R7 irq dropped", irqOut, 14'h0);
    setReg(8'h3C, 8'h15);
    getReg(8'h3C, v); chk("R8 low bits stored", v, 8'h15);
    setReg(8'h3C, 8'h6A);
    getReg(8'h3C, v); chk("R8 low bits kept on clear", v, 8'h15);
    ticks(5);
    flagNow(f); chk("R7 restarted from zero", f, 1'b0);
    ticks(1);
    flagNow(f); chk("R7 timer kept running", f, 1'b1);
    setReg(8'h37, 8'h00);
    flagNow(f); chk("R7 disable clears flag", f, 1'b0);
    chk("R7 irq off after disable", irqOut, 14'h0);
    ticks(8);
    flagNow(f); chk("R4 disabled does not count", f, 1'b0);
  endtask

  task automatic testResetPulse();
    setReg(8'h39, 8'h00);
    setReg(8'h38, 8'h10);
    setReg(8'h37, 8'h40);
    chk("R9 no pulse before tick", sysResetOut, 1'b0);
    ticks(1);
    chk("R9 pulse after first tick", sysResetOut, 1'b1);
    chk("R9 no irq for reset action", irqOut, 14'h0);
    @(negedge clk);
    chk("R9 pulse one cycle", sysResetOut, 1'b0);
    ticks(2);
    chk("R9 no repeat pulse", sysResetOut, 1'b0);
    setReg(8'h37, 8'h00);
  endtask

  task automatic testTopLine();
    logic f;
    setReg(8'h39, 8'h02);
    setReg(8'h38, 8'hF0);
    setReg(8'h37, 8'h40);
    ticks(2);
    chk("R9 line 13 idle", irqOut, 14'h0);
    ticks(1);
    chk("R9 line 13", irqOut, 14'h2000);
    setReg(8'h38, 8'h00);
    flagNow(f); chk("R9 action 0 flag still set", f, 1'b1);
    chk("R9 action 0 no irq", irqOut, 14'h0);
    chk("R9 action 0 no reset", sysResetOut, 1'b0);
    setReg(8'h37, 8'h00);
  endtask

  task automatic testWideAndLive();
    logic f;
    setReg(8'h39, 8'h00);
    setReg(8'h3A, 8'h01);
    setReg(8'h3B, 8'h00);
    setReg(8'h38, 8'h30);
    setReg(8'h37, 8'h40);
    ticks(256);
    flagNow(f); chk("R5 middle byte 256 ticks quiet", f, 1'b0);
    ticks(1);
    flagNow(f); chk("R5 middle byte fires at 257", f, 1'b1);
    chk("R9 line 1", irqOut, 14'h0002);
    setReg(8'h37, 8'h00);
    setReg(8'h3A, 8'h00);
    setReg(8'h39, 8'h64);
    setReg(8'h37, 8'h40);
    ticks(3);
    setReg(8'h39, 8'h01);
    flagNow(f); chk("R10 no tick yet", f, 1'b0);
    ticks(1);
    flagNow(f); chk("R10 lowered cmp applies next tick", f, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLock();
    testIrqTimeout();
    testClearStatus();
    testResetPulse();
    testTopLine();
    testWideAndLive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule